// File: doc/BRIEF.md
# Dispatch Skid Buffer Stall Controller

This block sits between a rename stage and the issue queue of an out-of-order core that runs several hardware threads. Each cycle rename delivers a bundle of up to `W` instructions for one thread. The block decides, for each thread on its own, whether that bundle goes straight to dispatch or is parked in that thread's skid buffer. It also tells earlier stages when the thread is blocked and when it has recovered.

Every thread runs its own four-state machine: running, blocked, unblocking and squashing. A thread stalls when commit reports that the reorder buffer is squashing, when the shared issue queue is full, or when that thread's load or store queue is full. A blocked thread parks everything that arrives. Once the stalls clear, it enters unblocking and empties its skid buffer, oldest entries first, ahead of any newer arrivals. A squash discards all the thread's buffered and arriving instructions. Each cycle the block reports, per thread, how many instructions left it, so that upstream free-entry accounting stays exact. It also reports the largest skid occupancy over all threads, which upstream uses for credit flow control, and a drained indication.

Top module: `dsk_dispatch_ctl`

## Requirements
- R1: After a synchronous active-high reset, every thread is running (state code 0), skid occupancy is 0, no dispatch lanes are valid, the overflow flags are clear, and `drained` is high when `in_cnt` is 0.
- R2: A thread that is running with no stall condition and no squash dispatches its arriving instructions in the same cycle. `disp_cnt` equals the number arriving, lanes are filled in arrival order from lane 0, and unused lanes are zero.
- R3: A running thread that sees any stall condition (`rob_squashing[t]`, `iq_full`, `lq_full[t]` or `sq_full[t]`) dispatches nothing. It pushes the arriving bundle into its skid buffer and enters blocked (code 1). `block_o[t]` is high in every cycle the thread is in blocked.
- R4: A blocked thread appends arrivals to its skid buffer and dispatches nothing. In the cycle after its stall conditions are all low, it is in unblocking (code 2).
- R5: An unblocking thread with no stall dispatches the min(occupancy, W) oldest skid entries, and same-cycle arrivals go behind them in the buffer. If a stall appears, it returns to blocked. When the buffer is left empty with no arrivals, the thread returns to running and `unblock_o[t]` pulses for exactly that one cycle.
- R6: A squash request empties the thread's skid buffer and discards its arriving bundle in the same cycle. The thread enters squashing (code 3). `rpt_total/loads/stores` count the instructions removed plus those dispatched that cycle, and an entry flagged as both load and store adds to both counts.
- R7: A squashing thread dispatches nothing and discards and reports its arrivals. It returns to running once `squash_req[t]` and `rob_squashing[t]` are both low.
- R8: Skid occupancy never exceeds `DEPTH`. Arrivals that do not fit are dropped, and `overflow[t]` is then set and stays set until reset.
- R9: `max_occ` equals the largest skid occupancy over all threads, taken from registered state.
- R10: `drained` is high exactly when every skid buffer is empty and `in_cnt` is 0.
- R11: Threads are independent: a bundle, stall or squash aimed at one thread does not change another thread's state, buffer or outputs, except through the shared `iq_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_tid | input | TIDW | Thread the arriving bundle belongs to |
| in_cnt | input | LW | Number of valid lanes in the bundle, lane 0 first |
| in_data | input | W*PW | Lane payloads, lane k at [k*PW +: PW] |
| in_is_ld | input | W | Lane is a load |
| in_is_st | input | W | Lane is a store or atomic |
| rob_squashing | input | NT | Per thread: commit reports a reorder-buffer squash |
| iq_full | input | 1 | Shared issue queue is full |
| lq_full | input | NT | Per-thread load queue full |
| sq_full | input | NT | Per-thread store queue full |
| squash_req | input | NT | Per-thread squash request |
| disp_cnt | output | NT*LW | Lanes dispatched per thread |
| disp_data | output | NT*W*PW | Dispatched payloads, thread t lane k at [(t*W+k)*PW +: PW] |
| disp_is_ld | output | NT*W | Dispatched lane is a load |
| disp_is_st | output | NT*W | Dispatched lane is a store |
| rpt_total | output | NT*RW | Instructions that left the block this cycle (dispatched or removed) |
| rpt_loads | output | NT*RW | Loads among them |
| rpt_stores | output | NT*RW | Stores among them |
| thr_state | output | NT*2 | State code: 0 running, 1 blocked, 2 unblocking, 3 squashing |
| block_o | output | NT | Thread is blocked; earlier stages must hold |
| unblock_o | output | NT | One-cycle pulse on the return to running from unblocking |
| overflow | output | NT | Sticky skid overflow |
| max_occ | output | CW | Largest skid occupancy across threads |
| drained | output | 1 | All skid buffers empty and no bundle arriving |

## Verification
The bench builds the block with two threads, a three-lane bundle and a skid depth of five. That depth is smaller than two full bundles, so two blocked cycles of full arrivals already overflow it and exercise the drop-and-flag path. An unblocking pass over five entries also takes two cycles, with the second a partial pop of min(occupancy, W). With two threads, the shared issue-queue stall and the per-thread stalls and squashes can be told apart, which is how the independence requirement is checked.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

    typedef enum logic [1:0] {
        TS_RUN = 2'd0,
        TS_BLK = 2'd1,
        TS_UNB = 2'd2,
        TS_SQ  = 2'd3
    } tstate_e;

    function automatic int umin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dsk_skid_fifo.sv
module dsk_skid_fifo
    import dsk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 2,
    parameter int EW    = 18,
    parameter int LW    = $clog2(W + 1),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [LW-1:0]     pop_n,
    input  logic [LW-1:0]     push_n,
    input  logic [W*EW-1:0]   push_data,
    output logic [CW-1:0]     cnt,
    output logic [W*EW-1:0]   head_data,
    output logic [CW-1:0]     buf_ld,
    output logic [CW-1:0]     buf_st,
    output logic              ovf
);
    localparam int PTRW = bits_for(DEPTH);

    logic [EW-1:0]   mem [DEPTH];
    logic [PTRW-1:0] rd_q;
    logic [CW-1:0]   cnt_q;
    logic            ovf_q;
    int              avail;
    int              space;
    int              acc;

    always_comb begin
        avail = int'(cnt_q) - int'(pop_n);
        space = DEPTH - avail;
        acc   = umin(int'(push_n), space);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (flush) begin
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            rd_q  <= PTRW'((int'(rd_q) + int'(pop_n)) % DEPTH);
            cnt_q <= CW'(avail + acc);
            if (int'(push_n) > space) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush) begin
            for (int j = 0; j < W; j++) begin
                if (j < acc)
                    mem[PTRW'((int'(rd_q) + int'(cnt_q) + j) % DEPTH)] <= push_data[j*EW +: EW];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < W; k++)
            head_data[k*EW +: EW] = mem[PTRW'((int'(rd_q) + k) % DEPTH)];
    end

    always_comb begin
        int nl;
        int ns;
        logic [EW-1:0] e;
        nl = 0;
        ns = 0;
        for (int i = 0; i < DEPTH; i++) begin
            e = mem[PTRW'((int'(rd_q) + i) % DEPTH)];
            if (i < int'(cnt_q)) begin
                nl = nl + int'(e[EW-1]);
                ns = ns + int'(e[EW-2]);
            end
        end
        buf_ld = CW'(nl);
        buf_st = CW'(ns);
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH);
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt_q == '0));
    assert_pop_avail_R5: assert property (@(posedge clk) disable iff (rst)
        pop_n <= cnt_q);

endmodule

// File: rtl/dsk_occ_max.sv
module dsk_occ_max #(
    parameter int NT = 2,
    parameter int CW = 4
) (
    input  logic [NT*CW-1:0] occ,
    output logic [CW-1:0]    mx
);
    always_comb begin
        mx = '0;
        for (int t = 0; t < NT; t++)
            if (occ[t*CW +: CW] > mx) mx = occ[t*CW +: CW];
    end
endmodule

// File: rtl/dsk_thread_ctl.sv
module dsk_thread_ctl
    import dsk_pkg::*;
#(
    parameter int THR   = 0,
    parameter int NT    = 2,
    parameter int W     = 2,
    parameter int DEPTH = 8,
    parameter int PW    = 16,
    parameter int TIDW  = bits_for(NT),
    parameter int LW    = $clog2(W + 1),
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int RW    = $clog2(DEPTH + W + 1),
    parameter int EW    = PW + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TIDW-1:0]  in_tid,
    input  logic [LW-1:0]    in_cnt,
    input  logic [W*EW-1:0]  in_data,
    input  logic             stall_rob,
    input  logic             stall_iq,
    input  logic             stall_lq,
    input  logic             stall_sq,
    input  logic             squash_req,
    output logic [LW-1:0]    disp_n,
    output logic [W*EW-1:0]  disp_data,
    output logic [RW-1:0]    rpt_tot,
    output logic [RW-1:0]    rpt_ld,
    output logic [RW-1:0]    rpt_st,
    output logic [1:0]       st_o,
    output logic             block_o,
    output logic             unblock_o,
    output logic             ovf_o,
    output logic [CW-1:0]    occ_o
);
    tstate_e st_q, st_nx;
    logic    unb_q;

    logic [CW-1:0]   f_cnt, f_bld, f_bst;
    logic [W*EW-1:0] f_head;
    logic            f_ovf;
    logic            flush;
    logic [LW-1:0]   pop_n, push_n;

    int   inc, in_ld, in_st;
    int   rem_t, rem_l, rem_s;
    int   d_l, d_s;
    logic stall, direct;

    always_comb begin
        inc   = (int'(in_tid) == THR) ? umin(int'(in_cnt), W) : 0;
        in_ld = 0;
        in_st = 0;
        for (int k = 0; k < W; k++) begin
            if (k < inc) begin
                in_ld = in_ld + int'(in_data[k*EW + EW - 1]);
                in_st = in_st + int'(in_data[k*EW + EW - 2]);
            end
        end
    end

    assign stall = stall_rob | stall_iq | stall_lq | stall_sq;

    always_comb begin
        st_nx  = st_q;
        flush  = 1'b0;
        pop_n  = '0;
        push_n = '0;
        direct = 1'b0;
        rem_t  = 0;
        rem_l  = 0;
        rem_s  = 0;
        if (squash_req) begin
            flush = 1'b1;
            st_nx = TS_SQ;
            rem_t = int'(f_cnt) + inc;
            rem_l = int'(f_bld) + in_ld;
            rem_s = int'(f_bst) + in_st;
        end else begin
            unique case (st_q)
                TS_RUN: begin
                    if (stall) begin
                        push_n = LW'(inc);
                        st_nx  = TS_BLK;
                    end else begin
                        direct = 1'b1;
                    end
                end
                TS_BLK: begin
                    push_n = LW'(inc);
                    if (!stall) st_nx = TS_UNB;
                end
                TS_UNB: begin
                    push_n = LW'(inc);
                    if (stall) begin
                        st_nx = TS_BLK;
                    end else begin
                        pop_n = LW'(umin(int'(f_cnt), W));
                        if ((int'(f_cnt) - int'(pop_n)) == 0 && inc == 0)
                            st_nx = TS_RUN;
                    end
                end
                TS_SQ: begin
                    rem_t = inc;
                    rem_l = in_ld;
                    rem_s = in_st;
                    if (!stall_rob) st_nx = TS_RUN;
                end
                default: st_nx = TS_RUN;
            endcase
        end
    end

    always_comb begin
        disp_data = '0;
        disp_n    = '0;
        if (direct) begin
            disp_n = LW'(inc);
            for (int k = 0; k < W; k++)
                if (k < inc) disp_data[k*EW +: EW] = in_data[k*EW +: EW];
        end else begin
            disp_n = pop_n;
            for (int k = 0; k < W; k++)
                if (k < int'(pop_n)) disp_data[k*EW +: EW] = f_head[k*EW +: EW];
        end
        d_l = 0;
        d_s = 0;
        for (int k = 0; k < W; k++) begin
            d_l = d_l + int'(disp_data[k*EW + EW - 1]);
            d_s = d_s + int'(disp_data[k*EW + EW - 2]);
        end
        rpt_tot = RW'(int'(disp_n) + rem_t);
        rpt_ld  = RW'(d_l + rem_l);
        rpt_st  = RW'(d_s + rem_s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TS_RUN;
            unb_q <= 1'b0;
        end else begin
            st_q  <= st_nx;
            unb_q <= (st_q == TS_UNB) && (st_nx == TS_RUN);
        end
    end

    dsk_skid_fifo #(
        .DEPTH(DEPTH), .W(W), .EW(EW), .LW(LW), .CW(CW)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .pop_n     (pop_n),
        .push_n    (push_n),
        .push_data (in_data),
        .cnt       (f_cnt),
        .head_data (f_head),
        .buf_ld    (f_bld),
        .buf_st    (f_bst),
        .ovf       (f_ovf)
    );

    assign st_o      = st_q;
    assign block_o   = (st_q == TS_BLK);
    assign unblock_o = unb_q;
    assign ovf_o     = f_ovf;
    assign occ_o     = f_cnt;

    assert_blocked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_BLK) |-> (disp_n == '0));
    assert_squash_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_SQ) |-> (disp_n == '0));
    assert_squash_enters_R6: assert property (@(posedge clk) disable iff (rst)
        squash_req |=> (st_q == TS_SQ));
    assert_unblock_origin_R5: assert property (@(posedge clk) disable iff (rst)
        unb_q |-> (st_q == TS_RUN && $past(st_q) == TS_UNB));
    assert_stall_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_RUN && stall && !squash_req) |=> (st_q == TS_BLK));

endmodule

// File: rtl/dsk_dispatch_ctl.sv
module dsk_dispatch_ctl
    import dsk_pkg::*;
#(
    parameter int NT    = 2,
    parameter int W     = 2,
    parameter int DEPTH = 8,
    parameter int PW    = 16,
    parameter int TIDW  = bits_for(NT),
    parameter int LW    = $clog2(W + 1),
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int RW    = $clog2(DEPTH + W + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TIDW-1:0]      in_tid,
    input  logic [LW-1:0]        in_cnt,
    input  logic [W*PW-1:0]      in_data,
    input  logic [W-1:0]         in_is_ld,
    input  logic [W-1:0]         in_is_st,
    input  logic [NT-1:0]        rob_squashing,
    input  logic                 iq_full,
    input  logic [NT-1:0]        lq_full,
    input  logic [NT-1:0]        sq_full,
    input  logic [NT-1:0]        squash_req,
    output logic [NT*LW-1:0]     disp_cnt,
    output logic [NT*W*PW-1:0]   disp_data,
    output logic [NT*W-1:0]      disp_is_ld,
    output logic [NT*W-1:0]      disp_is_st,
    output logic [NT*RW-1:0]     rpt_total,
    output logic [NT*RW-1:0]     rpt_loads,
    output logic [NT*RW-1:0]     rpt_stores,
    output logic [NT*2-1:0]      thr_state,
    output logic [NT-1:0]        block_o,
    output logic [NT-1:0]        unblock_o,
    output logic [NT-1:0]        overflow,
    output logic [CW-1:0]        max_occ,
    output logic                 drained
);
    localparam int EW = PW + 2;

    logic [W*EW-1:0]  in_ent;
    logic [NT*CW-1:0] occ_all;

    always_comb begin
        for (int k = 0; k < W; k++)
            in_ent[k*EW +: EW] = {in_is_ld[k], in_is_st[k], in_data[k*PW +: PW]};
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [W*EW-1:0] d_ent;

        dsk_thread_ctl #(
            .THR(t), .NT(NT), .W(W), .DEPTH(DEPTH), .PW(PW),
            .TIDW(TIDW), .LW(LW), .CW(CW), .RW(RW), .EW(EW)
        ) u_ctl (
            .clk        (clk),
            .rst        (rst),
            .in_tid     (in_tid),
            .in_cnt     (in_cnt),
            .in_data    (in_ent),
            .stall_rob  (rob_squashing[t]),
            .stall_iq   (iq_full),
            .stall_lq   (lq_full[t]),
            .stall_sq   (sq_full[t]),
            .squash_req (squash_req[t]),
            .disp_n     (disp_cnt[t*LW +: LW]),
            .disp_data  (d_ent),
            .rpt_tot    (rpt_total[t*RW +: RW]),
            .rpt_ld     (rpt_loads[t*RW +: RW]),
            .rpt_st     (rpt_stores[t*RW +: RW]),
            .st_o       (thr_state[t*2 +: 2]),
            .block_o    (block_o[t]),
            .unblock_o  (unblock_o[t]),
            .ovf_o      (overflow[t]),
            .occ_o      (occ_all[t*CW +: CW])
        );

        always_comb begin
            for (int k = 0; k < W; k++) begin
                disp_data[(t*W + k)*PW +: PW] = d_ent[k*EW +: PW];
                disp_is_st[t*W + k]           = d_ent[k*EW + EW - 2];
                disp_is_ld[t*W + k]           = d_ent[k*EW + EW - 1];
            end
        end
    end

    dsk_occ_max #(.NT(NT), .CW(CW)) u_max (
        .occ (occ_all),
        .mx  (max_occ)
    );

    assign drained = (occ_all == '0) && (in_cnt == '0);

    assert_max_bound_R9: assert property (@(posedge clk) disable iff (rst)
        int'(max_occ) <= DEPTH);
    assert_drained_idle_R10: assert property (@(posedge clk) disable iff (rst)
        drained |-> (max_occ == '0));

endmodule

// File: tb/dsk_dispatch_ctl_test.sv
module dsk_dispatch_ctl_test;
    localparam int NT = 2, W = 3, DEPTH = 5, PW = 8;
    localparam int TIDW = 1, LW = 2, CW = 3, RW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [TIDW-1:0] in_tid = '0;
    logic [LW-1:0] in_cnt = '0;
    logic [W*PW-1:0] in_data = '0;
    logic [W-1:0] in_is_ld = '0, in_is_st = '0;
    logic [NT-1:0] rob_squashing = '0, lq_full = '0, sq_full = '0, squash_req = '0;
    logic iq_full = 1'b0;
    logic [NT*LW-1:0] disp_cnt;
    logic [NT*W*PW-1:0] disp_data;
    logic [NT*W-1:0] disp_is_ld, disp_is_st;
    logic [NT*RW-1:0] rpt_total, rpt_loads, rpt_stores;
    logic [NT*2-1:0] thr_state;
    logic [NT-1:0] block_o, unblock_o, overflow;
    logic [CW-1:0] max_occ;
    logic drained;

    dsk_dispatch_ctl #(.NT(NT), .W(W), .DEPTH(DEPTH), .PW(PW)) uut (.*);

    always #2.5 clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [PW+1:0] mq [NT][DEPTH];
    int mcnt [NT];
    int mst [NT];
    bit movf [NT];
    bit munb [NT];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW+1:0] lane_in(input int k);
        return {in_is_ld[k], in_is_st[k], in_data[k*PW +: PW]};
    endfunction

    // Compare every output with the model, then advance the model one cycle.
    task automatic eval_step();
        int mx;
        mx = 0;
        for (int t = 0; t < NT; t++) if (mcnt[t] > mx) mx = mcnt[t];
        chk("R9 max_occ", 64'(max_occ), 64'(mx));
        chk("R10 drained", 64'(drained),
            64'((mcnt[0] == 0 && mcnt[1] == 0 && in_cnt == 0) ? 1 : 0));
        for (int t = 0; t < NT; t++) begin
            int inc, pop, nst, dn, rt, rl, rs, avail, space;
            bit stall, direct, push;
            logic [W*PW-1:0] ed;
            logic [W-1:0] el, es;
            string sfx;
            sfx = (t == 1) ? " R11 thr1" : " thr0";
            inc = (int'(in_tid) == t) ? int'(in_cnt) : 0;
            stall = rob_squashing[t] | iq_full | lq_full[t] | sq_full[t];
            nst = mst[t]; pop = 0; direct = 0; push = 0; rt = 0; rl = 0; rs = 0;
            chk({(mst[t]==1) ? "R4" : (mst[t]==2) ? "R5" : (mst[t]==3) ? "R7" : "R3", " state", sfx},
                64'(thr_state[t*2 +: 2]), 64'(mst[t]));
            chk({"R3 block", sfx}, 64'(block_o[t]), 64'(mst[t] == 1));
            chk({"R5 unblock", sfx}, 64'(unblock_o[t]), 64'(munb[t]));
            chk({"R8 overflow", sfx}, 64'(overflow[t]), 64'(movf[t]));
            if (squash_req[t]) begin
                nst = 3;
                for (int i = 0; i < mcnt[t]; i++) begin rt++; rl += mq[t][i][PW+1]; rs += mq[t][i][PW]; end
                for (int k = 0; k < inc; k++) begin rt++; rl += in_is_ld[k]; rs += in_is_st[k]; end
            end else begin
                case (mst[t])
                    0: if (stall) begin push = 1; nst = 1; end else direct = 1;
                    1: begin push = 1; if (!stall) nst = 2; end
                    2: begin
                        push = 1;
                        if (stall) nst = 1;
                        else begin
                            pop = (mcnt[t] < W) ? mcnt[t] : W;
                            if (mcnt[t] - pop == 0 && inc == 0) nst = 0;
                        end
                    end
                    default: begin
                        for (int k = 0; k < inc; k++) begin rt++; rl += in_is_ld[k]; rs += in_is_st[k]; end
                        if (!rob_squashing[t]) nst = 0;
                    end
                endcase
            end
            ed = '0; el = '0; es = '0; dn = 0;
            if (direct) begin
                dn = inc;
                for (int k = 0; k < inc; k++) begin
                    ed[k*PW +: PW] = in_data[k*PW +: PW]; el[k] = in_is_ld[k]; es[k] = in_is_st[k];
                end
            end else begin
                dn = pop;
                for (int k = 0; k < pop; k++) begin
                    ed[k*PW +: PW] = mq[t][k][PW-1:0]; el[k] = mq[t][k][PW+1]; es[k] = mq[t][k][PW];
                end
            end
            for (int k = 0; k < W; k++) begin rl += el[k]; rs += es[k]; end
            rt += dn;
            chk({(mst[t]==2) ? "R5" : "R2", " disp_cnt", sfx}, 64'(disp_cnt[t*LW +: LW]), 64'(dn));
            chk({(mst[t]==2) ? "R5" : "R2", " disp_data", sfx}, 64'(disp_data[t*W*PW +: W*PW]), 64'(ed));
            chk({"R2 disp_flags", sfx}, 64'({disp_is_ld[t*W +: W], disp_is_st[t*W +: W]}), 64'({el, es}));
            chk({"R6 rpt_total", sfx}, 64'(rpt_total[t*RW +: RW]), 64'(rt));
            chk({"R6 rpt_loads", sfx}, 64'(rpt_loads[t*RW +: RW]), 64'(rl));
            chk({"R6 rpt_stores", sfx}, 64'(rpt_stores[t*RW +: RW]), 64'(rs));
            // advance
            munb[t] = (mst[t] == 2 && nst == 0 && !squash_req[t]);
            if (squash_req[t]) mcnt[t] = 0;
            else begin
                for (int i = 0; i < DEPTH; i++) if (i + pop < DEPTH) mq[t][i] = mq[t][i + pop];
                mcnt[t] -= pop;
                if (push) begin
                    avail = mcnt[t]; space = DEPTH - avail;
                    if (inc > space) movf[t] = 1;
                    for (int k = 0; k < inc; k++) if (k < space) begin mq[t][mcnt[t]] = lane_in(k); mcnt[t]++; end
                end
            end
            mst[t] = nst;
        end
    endtask

    task automatic cyc(input int tid, input int cnt, input bit iq, input logic [1:0] lq,
                       input logic [1:0] sq, input logic [1:0] rob, input logic [1:0] sqr);
        @(negedge clk);
        in_tid = TIDW'(tid); in_cnt = LW'(cnt); in_data = W*PW'($urandom);
        in_is_ld = W'($urandom); in_is_st = W'($urandom);
        iq_full = iq; lq_full = lq; sq_full = sq; rob_squashing = rob; squash_req = sqr;
        #1;
        eval_step();
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int t = 0; t < NT; t++) begin mcnt[t] = 0; mst[t] = 0; movf[t] = 0; munb[t] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 state", 64'(thr_state), 64'(0));
        chk("R1 max_occ", 64'(max_occ), 64'(0));
        chk("R1 drained", 64'(drained), 64'(1));
        chk("R1 overflow", 64'(overflow), 64'(0));
        chk("R1 disp_cnt", 64'(disp_cnt), 64'(0));
        // directed: pass-through, block, overflow, drain, squash
        cyc(0, 3, 0, 0, 0, 0, 0);
        cyc(0, 3, 1, 0, 0, 0, 0);
        cyc(0, 3, 1, 0, 0, 0, 0);
        cyc(1, 2, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 3, 0, 2'b10, 0, 0, 0);
        cyc(1, 3, 0, 0, 0, 0, 2'b10);
        cyc(1, 2, 0, 0, 0, 2'b10, 0);
        cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        // random
        for (int n = 0; n < 4000; n++) begin
            cyc(int'($urandom % NT), int'($urandom % (W + 1)), ($urandom % 4) == 0,
                2'(($urandom % 10 == 0) ? 1 : 0) | 2'(($urandom % 10 == 0) ? 2 : 0),
                2'(($urandom % 12 == 0) ? 1 : 0) | 2'(($urandom % 12 == 0) ? 2 : 0),
                2'(($urandom % 14 == 0) ? 1 : 0) | 2'(($urandom % 14 == 0) ? 2 : 0),
                2'(($urandom % 30 == 0) ? 1 : 0) | 2'(($urandom % 30 == 0) ? 2 : 0));
        end
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule